// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block drains a circular ring of 32-bit command words that software places in system memory, and hands each usable word to a codec link. Software programs the following:

- a 128-byte-aligned ring base, written as two 32-bit halves;
- a write pointer that marks the last valid entry;
- a run bit;
- a threshold on the number of responses collected.

While running, the engine advances its own 8-bit read pointer. It issues one single-word read at a time on a simple request/response memory port and splits each returned word into a codec address, a node id and a payload.

A word is dropped without reaching the link in two cases: it asks for indirect node addressing, or it targets a codec slot with no codec present.

An immediate path lets software bypass the ring for a single command. Software loads a command word and raises a busy flag. The engine sends that word in preference to ring traffic and lowers the flag once the link has taken it.

Fetching pauses once the collected-response count, which a pulse from the response writer advances, equals the programmed threshold. It resumes when software acknowledges the response interrupt, which zeroes the count.

Top module: `cmd_ring_fetch`

## Requirements
- R1: Each forwarded word is split as codec address = bits 31:28, node id = bits 26:20, payload = bits 19:0, and presented on `cmd_cad`, `cmd_nid`, `cmd_payload` in ring order.
- R2: A word with bit 27 set is never presented on the link, yet the read pointer still moves past it.
- R3: A word (ring or immediate) whose codec address indexes a zero bit of `codec_present` is never presented on the link.
- R4: Before each fetch the read pointer is advanced by one modulo 256, and the read address is base + 4 × (new pointer); pointer 255 is followed by 0.
- R5: The base is {upper half, lower half}, and bits 6:0 of the lower half always read as zero whatever is written (select 0 = lower half, select 1 = upper half).
- R6: No read is issued while the run bit (select 3, bit 0) is clear, while the read pointer equals the write pointer (select 2), or while the response count equals the threshold (select 4).
- R7: Writing 1 to bit 0 of select 6 raises `imm_busy`; the word last written to select 5 is then sent before any further ring fetch. `imm_busy` falls when the link accepts it, or at once if the word is rejected under R2 or R3.
- R8: Each `rsp_collect` pulse adds one to the response count. Writing 1 to bit 0 of select 7 zeroes the count, so a fetch stalled by the threshold resumes.
- R9: At most one memory read is outstanding. `rd_ptr` changes only in the cycle after `mem_rsp_valid`.
- R10: `mem_req_valid` with its address, and `cmd_valid` with its fields, stay asserted and unchanged until the matching ready is seen.
- R11: After reset the read pointer is 0, the run bit is clear, `imm_busy` is low, and neither `mem_req_valid` nor `cmd_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 base low, 1 base high, 2 write pointer, 3 run, 4 threshold, 5 immediate word, 6 immediate go, 7 response acknowledge) |
| reg_wdata | input | 32 | Register write data |
| codec_present | input | 16 | One bit per codec address; 1 = codec attached |
| rsp_collect | input | 1 | Pulse from the response writer: one response collected |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory port accepts the request |
| mem_req_addr | output | 64 | Byte address of the ring entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (command word) |
| cmd_valid | output | 1 | Decoded command valid toward the codec link |
| cmd_ready | input | 1 | Codec link accepts the command |
| cmd_cad | output | 4 | Codec address |
| cmd_nid | output | 7 | Node id |
| cmd_payload | output | 20 | Verb and payload bits |
| rd_ptr | output | 8 | Current ring read pointer |
| imm_busy | output | 1 | Immediate command pending |

## Verification
The ring is first drained with ready memory and a ready link. These entries mix clean words with an indirect-flagged word and a word for an absent codec. This run separates correct field slicing from a rejection that wrongly drops words, or wrongly leaves the pointer behind.

Random-free periodic stalls on both the memory request and the link then show whether a request or command changes before it is taken. A long run of entries past pointer 255 exposes wrap and address errors.

Gating runs hold each stop condition in turn: run clear, an empty ring, and the count at the threshold. An acknowledge then releases the threshold stall.

Immediate commands are issued in three ways: on an idle engine, as rejected words, and while a ring command is stalled on the link. The last case distinguishes true priority from simple arrival order.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

    // Command word layout (fixed by the link format)
    localparam int WORD_W     = 32;
    localparam int CAD_W      = 4;
    localparam int NID_W      = 7;
    localparam int PAY_W      = 20;
    localparam int CAD_LSB    = 28;
    localparam int IND_BIT    = 27;
    localparam int NID_LSB    = 20;
    localparam int NUM_CODECS = 1 << CAD_W;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2,
        FS_SEND = 2'd3
    } fetch_state_e;

    typedef enum logic [2:0] {
        RS_BASE_LO  = 3'd0,
        RS_BASE_HI  = 3'd1,
        RS_WPTR     = 3'd2,
        RS_RUN      = 3'd3,
        RS_THRESH   = 3'd4,
        RS_IMM_WORD = 3'd5,
        RS_IMM_GO   = 3'd6,
        RS_RSP_ACK  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [CAD_W-1:0] cad;
        logic [NID_W-1:0] nid;
        logic [PAY_W-1:0] payload;
    } cmd_t;

endpackage

// File: rtl/cmd_word_split.sv
module cmd_word_split
    import cmd_ring_pkg::*;
(
    input  logic [WORD_W-1:0]     word,
    input  logic [NUM_CODECS-1:0] present,
    output cmd_t                  fields,
    output logic                  accept
);
    always_comb begin
        fields.cad     = word[CAD_LSB +: CAD_W];
        fields.nid     = word[NID_LSB +: NID_W];
        fields.payload = word[PAY_W-1:0];
        // indirect addressing is unsupported; absent codecs get nothing
        accept         = !word[IND_BIT] && present[fields.cad];
    end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
    parameter int HALF_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [HALF_W-1:0]   base_lo,
    input  logic [HALF_W-1:0]   base_hi,
    input  logic [IDX_W-1:0]    idx,
    output logic [2*HALF_W-1:0] addr
);
    localparam int ADDR_W     = 2 * HALF_W;
    localparam int WORD_SHIFT = 2;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = ADDR_W'({idx, {WORD_SHIFT{1'b0}}});
        addr   = {base_hi, base_lo} + offset;
    end
endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int HALF_W     = 32,  // must be >= WORD_W
    parameter int PTR_W      = 8,
    parameter int CNT_W      = 8,
    parameter int ALIGN_BITS = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [2:0]            reg_sel,
    input  logic [HALF_W-1:0]     reg_wdata,
    input  logic [NUM_CODECS-1:0] codec_present,
    input  logic                  rsp_collect,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [2*HALF_W-1:0]   mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [WORD_W-1:0]     mem_rsp_data,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [CAD_W-1:0]      cmd_cad,
    output logic [NID_W-1:0]      cmd_nid,
    output logic [PAY_W-1:0]      cmd_payload,
    output logic [PTR_W-1:0]      rd_ptr,
    output logic                  imm_busy
);
    typedef struct packed {
        fetch_state_e      st;
        logic [HALF_W-1:0] base_lo;
        logic [HALF_W-1:0] base_hi;
        logic [PTR_W-1:0]  wp;
        logic [PTR_W-1:0]  rp;
        logic              run;
        logic [CNT_W-1:0]  thresh;
        logic [CNT_W-1:0]  rcnt;
        logic [WORD_W-1:0] imm_word;
        logic              imm_busy;
        cmd_t              held;
        logic              held_imm;
    } state_t;

    state_t q, d;

    cmd_t             imm_f, rsp_f;
    logic             imm_ok, rsp_ok;
    logic [PTR_W-1:0] next_idx;
    logic             fetch_ok;

    cmd_word_split u_imm_split (
        .word    (q.imm_word),
        .present (codec_present),
        .fields  (imm_f),
        .accept  (imm_ok)
    );

    cmd_word_split u_rsp_split (
        .word    (mem_rsp_data),
        .present (codec_present),
        .fields  (rsp_f),
        .accept  (rsp_ok)
    );

    ring_addr_gen #(
        .HALF_W (HALF_W),
        .IDX_W  (PTR_W)
    ) u_addr (
        .base_lo (q.base_lo),
        .base_hi (q.base_hi),
        .idx     (next_idx),
        .addr    (mem_req_addr)
    );

    always_comb begin
        d        = q;
        next_idx = q.rp + 1'b1;
        fetch_ok = q.run && (q.rp != q.wp) && (q.rcnt != q.thresh);

        unique case (q.st)
            FS_IDLE: begin
                if (q.imm_busy) begin
                    if (imm_ok) begin
                        d.held     = imm_f;
                        d.held_imm = 1'b1;
                        d.st       = FS_SEND;
                    end else begin
                        d.imm_busy = 1'b0;
                    end
                end else if (fetch_ok) begin
                    d.st = FS_REQ;
                end
            end
            FS_REQ: begin
                if (mem_req_ready) d.st = FS_WAIT;
            end
            FS_WAIT: begin
                if (mem_rsp_valid) begin
                    d.rp = next_idx;
                    if (rsp_ok) begin
                        d.held     = rsp_f;
                        d.held_imm = 1'b0;
                        d.st       = FS_SEND;
                    end else begin
                        d.st = FS_IDLE;
                    end
                end
            end
            FS_SEND: begin
                if (cmd_ready) begin
                    d.st = FS_IDLE;
                    if (q.held_imm) d.imm_busy = 1'b0;
                end
            end
            default: d.st = FS_IDLE;
        endcase

        if (rsp_collect) d.rcnt = q.rcnt + 1'b1;

        // software writes take effect after the engine's own updates
        if (reg_we) begin
            case (reg_sel_e'(reg_sel))
                RS_BASE_LO:  d.base_lo = {reg_wdata[HALF_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                RS_BASE_HI:  d.base_hi = reg_wdata;
                RS_WPTR:     d.wp = reg_wdata[PTR_W-1:0];
                RS_RUN:      d.run = reg_wdata[0];
                RS_THRESH:   d.thresh = reg_wdata[CNT_W-1:0];
                RS_IMM_WORD: d.imm_word = reg_wdata[WORD_W-1:0];
                RS_IMM_GO:   if (reg_wdata[0]) d.imm_busy = 1'b1;
                RS_RSP_ACK:  if (reg_wdata[0]) d.rcnt = '0;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req_valid = (q.st == FS_REQ);
    assign cmd_valid     = (q.st == FS_SEND);
    assign cmd_cad       = q.held.cad;
    assign cmd_nid       = q.held.nid;
    assign cmd_payload   = q.held.payload;
    assign rd_ptr        = q.rp;
    assign imm_busy      = q.imm_busy;

    // pointer moves only on returned read data
    assert_rp_on_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr != $past(rd_ptr)) |-> $past(mem_rsp_valid));

    // a read starts only when the gate conditions held in the deciding cycle
    assert_fetch_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(q.run && (q.rp != q.wp) && (q.rcnt != q.thresh)));

    // memory request is held until taken
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // link command is held until taken
    assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable({cmd_cad, cmd_nid, cmd_payload})));

    // nothing reaches an absent codec
    assert_codec_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> codec_present[cmd_cad]);

    // a pending immediate blocks a ring fetch from starting
    assert_imm_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FS_IDLE && q.imm_busy) |=> !mem_req_valid);

endmodule

// File: tb/sim_cmd_ring_fetch.sv
module sim_cmd_ring_fetch;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 2;
    localparam int CYC_LIMIT  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [15:0] codec_present = 16'h0025;
    logic        rsp_collect = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b0;
    logic [3:0]  cmd_cad;
    logic [6:0]  cmd_nid;
    logic [19:0] cmd_payload;
    logic [7:0]  rd_ptr;
    logic        imm_busy;

    cmd_ring_fetch u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .codec_present(codec_present),
        .rsp_collect(rsp_collect), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_cad(cmd_cad),
        .cmd_nid(cmd_nid), .cmd_payload(cmd_payload), .rd_ptr(rd_ptr),
        .imm_busy(imm_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [31:0] ring [256];
    logic [63:0] m_base = '0;
    int          m_rp = 0;
    int          m_wp = 0;
    logic [31:0] exp_q [$];
    int          req_cnt = 0;
    int          cmd_cnt = 0;
    bit          pend = 0;
    int          mem_delay = 0;
    logic [63:0] pend_addr = '0;
    logic [63:0] last_addr = '0;
    bit          rdy_stall = 0;
    bit          cmd_stall = 0;
    bit          cmd_hold = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one clock: drive after the edge, compare against the model at negedge
    task automatic tick();
        logic [63:0] exp_addr;
        logic [31:0] w;
        logic [31:0] e;
        @(posedge clk);
        #1;
        cyc++;
        if (cyc > CYC_LIMIT) begin
            check(1'b0, "R10", "watchdog expired cycles", 64'(cyc), 64'(CYC_LIMIT));
            finish_run();
        end
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (mem_delay == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = ring[((pend_addr - m_base) >> 2) & 64'hff];
                pend = 0;
            end else begin
                mem_delay--;
            end
        end
        mem_req_ready = rdy_stall ? (cyc % 3 != 0) : 1'b1;
        cmd_ready     = cmd_hold ? 1'b0 : (cmd_stall ? (cyc % 2 == 0) : 1'b1);
        @(negedge clk);
        // R9: pointer tracks the returned reads one for one
        check(rd_ptr == 8'(m_rp), "R9", "rd_ptr", 64'(rd_ptr), 64'(m_rp));
        if (mem_req_valid && mem_req_ready) begin
            exp_addr = m_base + 64'(((m_rp + 1) % 256) * 4);
            check(mem_req_addr == exp_addr, "R4", "fetch address", mem_req_addr, exp_addr);
            check(!pend, "R9", "second outstanding read", 64'(pend), 64'd0);
            req_cnt++;
            pend      = 1;
            mem_delay = MEM_LAT;
            pend_addr = mem_req_addr;
            last_addr = mem_req_addr;
        end
        if (mem_rsp_valid) begin
            m_rp = (m_rp + 1) % 256;
            w = mem_rsp_data;
            if (!w[27] && codec_present[w[31:28]]) exp_q.push_back(w);
        end
        if (cmd_valid && cmd_ready) begin
            cmd_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected command", {cmd_cad, 1'b0, cmd_nid, cmd_payload}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                check({cmd_cad, cmd_nid, cmd_payload} == {e[31:28], e[26:20], e[19:0]},
                      "R1", "command fields", {cmd_cad, 1'b0, cmd_nid, cmd_payload}, e);
            end
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        if (sel == 3'd0) m_base[31:0]  = data & ~32'h7f;
        if (sel == 3'd1) m_base[63:32] = data;
        if (sel == 3'd2) m_wp = int'(data[7:0]);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic pulse_collect();
        rsp_collect = 1'b1;
        tick();
        rsp_collect = 1'b0;
    endtask

    task automatic idle_n(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wait_idle(input int limit);
        for (int k = 0; k < limit; k++) begin
            tick();
            if (exp_q.size() == 0 && !pend && m_rp == m_wp &&
                !cmd_valid && !mem_req_valid && !imm_busy) break;
        end
        idle_n(3);
    endtask

    initial begin
        int r0;
        int c0;
        logic [3:0]  c;
        logic [31:0] w1;
        for (int i = 0; i < 256; i++) begin
            c = (i % 3 == 0) ? 4'd0 : ((i % 3 == 1) ? 4'd2 : 4'd5);
            ring[i] = {c, 1'b0, 7'(i * 5), 20'(i * 4099 + 7)};
        end
        ring[2] = ring[2] | 32'h0800_0000;        // indirect flag
        ring[3] = {4'h1, ring[3][27:0]};          // absent codec

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(rd_ptr == 8'd0, "R11", "rd_ptr after reset", 64'(rd_ptr), 64'd0);
        check(!mem_req_valid, "R11", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
        check(!cmd_valid, "R11", "cmd_valid after reset", 64'(cmd_valid), 64'd0);
        check(!imm_busy, "R11", "imm_busy after reset", 64'(imm_busy), 64'd0);

        // R1 R2 R3 R5: first drain with clean and rejected words
        wr(3'd0, 32'h1234_56FF);
        wr(3'd1, 32'h0000_00AB);
        wr(3'd4, 32'd255);
        idle_n(10);
        check(req_cnt == 0, "R11", "no fetch while run clear after reset", 64'(req_cnt), 64'd0);
        wr(3'd3, 32'd1);
        wr(3'd2, 32'd5);
        wait_idle(500);
        check(rd_ptr == 8'd5, "R2", "pointer past rejected words", 64'(rd_ptr), 64'd5);
        check(req_cnt == 5, "R9", "reads for five entries", 64'(req_cnt), 64'd5);
        check(cmd_cnt == 3, "R3", "commands forwarded", 64'(cmd_cnt), 64'd3);
        check(last_addr == 64'h0000_00AB_1234_5680 + 64'd20, "R5", "aligned base address",
              last_addr, 64'h0000_00AB_1234_5680 + 64'd20);

        // R10: stalls on both sides
        rdy_stall = 1; cmd_stall = 1;
        wr(3'd2, 32'd12);
        wait_idle(800);
        check(rd_ptr == 8'd12, "R10", "drain under backpressure", 64'(rd_ptr), 64'd12);
        check(exp_q.size() == 0, "R10", "all commands delivered", 64'(exp_q.size()), 64'd0);
        rdy_stall = 0; cmd_stall = 0;

        // R4: run past pointer 255
        wr(3'd2, 32'd3);
        wait_idle(4000);
        check(rd_ptr == 8'd3, "R4", "pointer after wrap", 64'(rd_ptr), 64'd3);
        check(last_addr == m_base + 64'd12, "R4", "address after wrap", last_addr, m_base + 64'd12);

        // R6: run clear
        wr(3'd3, 32'd0);
        r0 = req_cnt;
        wr(3'd2, 32'd8);
        idle_n(20);
        check(req_cnt == r0, "R6", "no read with run clear", 64'(req_cnt), 64'(r0));
        check(rd_ptr == 8'd3, "R6", "pointer frozen with run clear", 64'(rd_ptr), 64'd3);
        wr(3'd3, 32'd1);
        wait_idle(500);
        check(rd_ptr == 8'd8, "R6", "resume after run set", 64'(rd_ptr), 64'd8);

        // R6: empty ring
        r0 = req_cnt;
        idle_n(20);
        check(req_cnt == r0, "R6", "no read on empty ring", 64'(req_cnt), 64'(r0));

        // R6 R8: threshold gating and acknowledge
        wr(3'd4, 32'd2);
        pulse_collect();
        pulse_collect();
        r0 = req_cnt;
        wr(3'd2, 32'd11);
        idle_n(20);
        check(req_cnt == r0, "R6", "no read at threshold", 64'(req_cnt), 64'(r0));
        wr(3'd7, 32'd1);
        wait_idle(500);
        check(rd_ptr == 8'd11, "R8", "resume after acknowledge", 64'(rd_ptr), 64'd11);
        pulse_collect();
        wr(3'd2, 32'd13);
        wait_idle(500);
        check(rd_ptr == 8'd13, "R8", "count below threshold keeps fetching", 64'(rd_ptr), 64'd13);
        wr(3'd7, 32'd1);
        wr(3'd4, 32'd255);

        // R7: immediate on idle engine, then rejected ones
        wr(3'd3, 32'd0);
        w1 = {4'd2, 1'b0, 7'd17, 20'hABCDE};
        wr(3'd5, w1);
        exp_q.push_back(w1);
        wr(3'd6, 32'd1);
        wait_idle(100);
        check(!imm_busy, "R7", "busy clears after send", 64'(imm_busy), 64'd0);
        check(exp_q.size() == 0, "R7", "immediate delivered", 64'(exp_q.size()), 64'd0);
        c0 = cmd_cnt;
        wr(3'd5, w1 | 32'h0800_0000);
        wr(3'd6, 32'd1);
        wait_idle(100);
        check(!imm_busy, "R2", "busy clears on indirect immediate", 64'(imm_busy), 64'd0);
        wr(3'd5, {4'd1, w1[27:0]});
        wr(3'd6, 32'd1);
        wait_idle(100);
        check(!imm_busy, "R3", "busy clears on absent codec immediate", 64'(imm_busy), 64'd0);
        check(cmd_cnt == c0, "R3", "rejected immediates not sent", 64'(cmd_cnt), 64'(c0));

        // R7: immediate overtakes pending ring work
        cmd_hold = 1;
        wr(3'd3, 32'd1);
        wr(3'd2, 32'd16);
        for (int k = 0; k < 100; k++) begin
            if (cmd_valid) break;
            tick();
        end
        w1 = {4'd5, 1'b0, 7'd99, 20'h13579};
        wr(3'd5, w1);
        exp_q.push_back(w1);
        wr(3'd6, 32'd1);
        check(imm_busy, "R7", "busy raised while link stalled", 64'(imm_busy), 64'd1);
        check(rd_ptr == 8'd14, "R7", "no ring fetch while held", 64'(rd_ptr), 64'd14);
        cmd_hold = 0;
        wait_idle(500);
        check(rd_ptr == 8'd16, "R7", "ring completes after immediate", 64'(rd_ptr), 64'd16);
        check(exp_q.size() == 0, "R7", "order ring, immediate, ring", 64'(exp_q.size()), 64'd0);

        finish_run();
    end
endmodule